// File: doc/BRIEF.md
# Single-channel remote register access sequencer

This block lets one host reach the registers of a remote serial device through a single command register. The host writes a 32-bit command word that carries a direction bit, a halfword address and 16 bits of write data. A small state machine then carries the transaction across a request/acknowledge link port. Writes finish as soon as the link accepts them. Reads wait for the returned data and then stay parked, holding that data, until the host releases them with a valid-clear strobe.

A 32-bit status word reports the sequencer state, whether the link is quiet (sync-idle), whether initialisation has been declared complete, and whether a command was lost because the channel was busy. While a read is parked, the status word also carries the returned data. A channel enable gates command intake. The host is expected to poll the status word until the state reads idle before it issues a new command.

Top module: `regacc_chan`

## Requirements
- R1: After reset the status word is 0x0010_0000: state field 0 (idle), sync-idle bit set, init-done and overrun clear, data field zero.
- R2: An accepted command word is decoded as follows. Bit 31 set means write and clear means read. Bits 30:16 hold the byte address shifted right by one. Bits 15:0 hold the write data. These values appear on `link_wr`, `link_haddr` and `link_wdata` in the cycle after acceptance.
- R3: A write moves from the request state (code 1) straight back to idle (code 0) on the first cycle `link_ack` is high, without visiting codes 2 or 3.
- R4: A read moves from request to wait-for-data (code 2) on `link_ack`. It then moves to wait-for-valid-clear (code 3) on `link_rvalid`, capturing `link_rdata`.
- R5: In code 3 the state holds for as long as `vldclr_we` stays low, and status bits 15:0 show the captured read data. In every other state those bits read zero.
- R6: `vldclr_we` in state 3 returns the channel to idle on the next cycle. In any other state it has no effect on the status word.
- R7: Status bit 20 (sync-idle) is low exactly while the state is 1 or 2, that is, while a link transfer is outstanding.
- R8: A command written while the state is not idle is ignored: the link payload and the transaction in flight are unchanged. It also sets status bit 22 (overrun), which stays set until reset.
- R9: While `chan_en` is low, command writes are dropped: the state stays idle, `link_req` stays low and the overrun bit is not set.
- R10: A pulse on `init_set` sets status bit 21 (init-done), which stays set until reset.
- R11: `link_req` stays high with a stable payload from acceptance until `link_ack` is seen. It is low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 1 | Channel enable for command intake |
| init_set | input | 1 | Pulse that marks initialisation complete |
| cmd_we | input | 1 | Command register write strobe |
| cmd_word | input | 32 | Command word |
| vldclr_we | input | 1 | Valid-clear strobe releasing a parked read |
| status | output | 32 | Status word: data, state, sync-idle, init-done, overrun |
| link_req | output | 1 | Link transfer request |
| link_wr | output | 1 | Link direction, 1 = write |
| link_haddr | output | 15 | Link halfword address |
| link_wdata | output | 16 | Link write data |
| link_ack | input | 1 | Link accepted the request |
| link_rvalid | input | 1 | Link read data valid |
| link_rdata | input | 16 | Link read data |

## Verification
A wrong state in the sequencer is visible in the status word on the very next cycle. The state field, the sync-idle bit and the data field all derive from it, so a parked read that leaks back to idle, or a write that detours through wait-for-data, shows within one clock. A wrongly latched command shows on the link payload in the cycle after acceptance. A dropped or swapped read result reaches the data field when the read parks, where a scoreboard compares it with its own model of the remote registers. A command that should have been ignored but was taken shows either as a payload change while the request is pending or as a later read that returns the wrong value.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  localparam int DATA_W  = 16;
  localparam int HADDR_W = 15;
  localparam int STATE_W = 3;
  localparam int WORD_W  = 32;

  // status word positions
  localparam int STS_STATE_LSB = 16;
  localparam int STS_SYNC_BIT  = 20;
  localparam int STS_INIT_BIT  = 21;
  localparam int STS_OVR_BIT   = 22;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE     = 3'd0,
    ST_REQ      = 3'd1,
    ST_WFDLE    = 3'd2,
    ST_WFVLDCLR = 3'd3
  } chan_state_e;

  typedef struct packed {
    logic               wr;
    logic [HADDR_W-1:0] haddr;
    logic [DATA_W-1:0]  wdata;
  } cmd_t;

  // split a host command word into its fields
  function automatic cmd_t decode_cmd(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.wr    = w[WORD_W-1];
    c.haddr = w[DATA_W +: HADDR_W];
    c.wdata = w[DATA_W-1:0];
    return c;
  endfunction

  // assemble the status word
  function automatic logic [WORD_W-1:0] pack_status(
    input chan_state_e       st,
    input logic              sync_idle,
    input logic              init_done,
    input logic              overrun,
    input logic [DATA_W-1:0] rdata);
    logic [WORD_W-1:0] s;
    s = '0;
    s[DATA_W-1:0] = rdata;
    s[STS_STATE_LSB +: STATE_W] = st;
    s[STS_SYNC_BIT] = sync_idle;
    s[STS_INIT_BIT] = init_done;
    s[STS_OVR_BIT]  = overrun;
    return s;
  endfunction

  // true while a link transfer is outstanding
  function automatic logic link_busy(input chan_state_e st);
    return (st == ST_REQ) || (st == ST_WFDLE);
  endfunction
endpackage

// File: rtl/regacc_fsm.sv
module regacc_fsm
  import regacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               cmd_we,
  input  cmd_t               cmd_in,
  input  logic               vldclr_we,
  input  logic               link_ack,
  input  logic               link_rvalid,
  output chan_state_e        state,
  output logic               link_req,
  output logic               link_wr,
  output logic [HADDR_W-1:0] link_haddr,
  output logic [DATA_W-1:0]  link_wdata,
  output logic               overrun,
  output logic               rd_capture
);
  cmd_t cmd_q;
  logic cmd_accept, cmd_drop_busy, vldclr_hit;

  assign cmd_accept    = cmd_we && chan_en && (state == ST_IDLE);
  assign cmd_drop_busy = cmd_we && chan_en && (state != ST_IDLE);
  assign rd_capture    = (state == ST_WFDLE) && link_rvalid;
  assign vldclr_hit    = (state == ST_WFVLDCLR) && vldclr_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cmd_q   <= '0;
      overrun <= 1'b0;
    end else begin
      if (cmd_drop_busy) overrun <= 1'b1;
      case (state)
        ST_IDLE: if (cmd_accept) begin
          cmd_q <= cmd_in;
          state <= ST_REQ;
        end
        ST_REQ:      if (link_ack) state <= cmd_q.wr ? ST_IDLE : ST_WFDLE;
        ST_WFDLE:    if (rd_capture) state <= ST_WFVLDCLR;
        ST_WFVLDCLR: if (vldclr_hit) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assign link_req   = (state == ST_REQ);
  assign link_wr    = cmd_q.wr;
  assign link_haddr = cmd_q.haddr;
  assign link_wdata = cmd_q.wdata;

  p_write_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && link_ack && link_wr) |=> (state == ST_IDLE));
  p_read_to_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REQ && link_ack && !link_wr) |=> (state == ST_WFDLE));
  p_read_parked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WFVLDCLR && !vldclr_we) |=> (state == ST_WFVLDCLR));
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vldclr_hit |=> (state == ST_IDLE));
  p_busy_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop_busy |=> overrun);
  p_busy_keeps_payload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_drop_busy |=> ($stable(link_haddr) && $stable(link_wdata) && $stable(link_wr)));
  p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !chan_en) |=> (state == ST_IDLE));
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req && !link_ack) |=> (link_req && $stable(link_haddr)));
endmodule

// File: rtl/regacc_rdbuf.sv
module regacc_rdbuf #(
  parameter int DATA_W = regacc_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] rdata_in,
  input  logic              show,
  output logic [DATA_W-1:0] rdata_out
);
  logic [DATA_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n)       held <= '0;
    else if (capture) held <= rdata_in;
  end

  assign rdata_out = show ? held : '0;

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (held == $past(rdata_in)));
endmodule

// File: rtl/regacc_chan.sv
module regacc_chan
  import regacc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               chan_en,
  input  logic               init_set,
  input  logic               cmd_we,
  input  logic [WORD_W-1:0]  cmd_word,
  input  logic               vldclr_we,
  output logic [WORD_W-1:0]  status,
  output logic               link_req,
  output logic               link_wr,
  output logic [HADDR_W-1:0] link_haddr,
  output logic [DATA_W-1:0]  link_wdata,
  input  logic               link_ack,
  input  logic               link_rvalid,
  input  logic [DATA_W-1:0]  link_rdata
);
  chan_state_e       state;
  logic              overrun, rd_capture, init_done, sync_idle;
  logic [DATA_W-1:0] rd_shown;

  regacc_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .cmd_we(cmd_we),
    .cmd_in(decode_cmd(cmd_word)), .vldclr_we(vldclr_we),
    .link_ack(link_ack), .link_rvalid(link_rvalid), .state(state),
    .link_req(link_req), .link_wr(link_wr), .link_haddr(link_haddr),
    .link_wdata(link_wdata), .overrun(overrun), .rd_capture(rd_capture)
  );

  regacc_rdbuf #(.DATA_W(DATA_W)) u_rdbuf (
    .clk(clk), .rst_n(rst_n), .capture(rd_capture), .rdata_in(link_rdata),
    .show(state == ST_WFVLDCLR), .rdata_out(rd_shown)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        init_done <= 1'b0;
    else if (init_set) init_done <= 1'b1;
  end

  assign sync_idle = !link_busy(state);
  assign status    = pack_status(state, sync_idle, init_done, overrun, rd_shown);

  p_sync_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    link_req |-> !status[STS_SYNC_BIT]);
  p_init_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    init_set |=> status[STS_INIT_BIT]);
  p_data_hidden_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status[STS_STATE_LSB +: STATE_W] != ST_WFVLDCLR) |-> (status[DATA_W-1:0] == '0));
endmodule

// File: tb/sim_regacc_chan.sv
module sim_regacc_chan;
  localparam int LAT = 3;
  logic clk = 0, rst_n = 0, chan_en = 0, init_set = 0, cmd_we = 0, vldclr_we = 0;
  logic [31:0] cmd_word = '0;
  logic [31:0] status;
  logic link_req, link_wr, link_ack = 0, link_rvalid = 0;
  logic [14:0] link_haddr;
  logic [15:0] link_wdata, link_rdata = '0;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  logic [15:0] dev_mem [16];
  logic [15:0] exp_mem [16];
  logic [15:0] exp_q [$];
  bit taken = 0;

  always #2 clk = ~clk;

  regacc_chan u0 (.*);

  function automatic logic [2:0] st_f(); return status[18:16]; endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // remote device with fixed latency
  initial begin
    for (int i = 0; i < 16; i++) dev_mem[i] = 16'hA500 + 16'(i * 3);
    forever begin
      @(negedge clk);
      if (link_req) begin
        logic wr; logic [3:0] a; logic [15:0] d;
        wr = link_wr; a = link_haddr[3:0]; d = link_wdata;
        repeat (LAT - 1) @(negedge clk);
        link_ack = 1;
        @(negedge clk);
        link_ack = 0;
        if (wr) dev_mem[a] = d;
        else begin
          repeat (LAT - 1) @(negedge clk);
          link_rdata = dev_mem[a]; link_rvalid = 1;
          @(negedge clk);
          link_rvalid = 0; link_rdata = '0;
        end
      end
    end
  end

  // scoreboard monitor
  initial forever begin
    @(negedge clk);
    if (st_f() == 3'd3 && !taken) begin
      taken = 1;
      if (exp_q.size() == 0) chk("R4 unexpected read", status[15:0], 32'hFFFF_FFFF);
      else chk("R4/R5 read data", status[15:0], exp_q.pop_front());
    end else if (st_f() != 3'd3) taken = 0;
  end

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        n_bad++; n_cmp++;
        $display("FAIL watchdog act=%0d exp=<20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  function automatic logic [31:0] mk(bit wr, int baddr, logic [15:0] d);
    return {wr, 15'(baddr >> 1), d};
  endfunction

  task automatic issue(bit wr, int baddr, logic [15:0] d);
    @(negedge clk); cmd_word = mk(wr, baddr, d); cmd_we = 1;
    @(negedge clk); cmd_we = 0;
  endtask

  task automatic do_write(int baddr, logic [15:0] d);
    bit bad = 0;
    issue(1, baddr, d);
    chk("R2 link_wr", link_wr, 1);
    chk("R2 link_haddr", link_haddr, 32'(baddr >> 1));
    chk("R2 link_wdata", link_wdata, d);
    chk("R7 sync low in req", status[20], 0);
    for (int k = 0; k < 40 && st_f() != 0; k++) begin
      chk("R11 req held", link_req, 1);
      @(negedge clk);
      if (st_f() == 2 || st_f() == 3) bad = 1;
    end
    chk("R3 write straight to idle", {bad, st_f()}, 0);
    exp_mem[(baddr >> 1) & 15] = d;
  endtask

  task automatic do_read(int baddr);
    exp_q.push_back(exp_mem[(baddr >> 1) & 15]);
    issue(0, baddr, 16'h0);
    chk("R2 read dir", link_wr, 0);
    chk("R2 read haddr", link_haddr, 32'(baddr >> 1));
    for (int k = 0; k < 40 && st_f() == 1; k++) @(negedge clk);
    chk("R4 wait-for-data", st_f(), 2);
    chk("R7 sync low in wfdle", status[20], 0);
    chk("R11 req low in wfdle", link_req, 0);
    for (int k = 0; k < 40 && st_f() == 2; k++) @(negedge clk);
    chk("R4 parked", st_f(), 3);
    chk("R7 sync high parked", status[20], 1);
    repeat (5) @(negedge clk);
    chk("R5 still parked", st_f(), 3);
    vldclr_we = 1; @(negedge clk); vldclr_we = 0;
    chk("R6 released", st_f(), 0);
    chk("R5 data zero in idle", status[15:0], 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) exp_mem[i] = 16'hA500 + 16'(i * 3);
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    chk("R1 reset status", status, 32'h0010_0000);
    chan_en = 1;

    // R9: disabled drops
    chan_en = 0;
    issue(1, 4, 16'hDEAD);
    chk("R9 state idle", st_f(), 0);
    chk("R9 no req", link_req, 0);
    chk("R9 no overrun", status[22], 0);
    repeat (8) @(negedge clk);
    chan_en = 1;

    // R6: valid-clear in idle
    vldclr_we = 1; @(negedge clk); vldclr_we = 0;
    chk("R6 vldclr idle no effect", status, 32'h0010_0000);

    do_read(4);                 // old value, confirms R9 drop
    do_write(6, 16'h1234);
    do_read(6);
    do_write(0, 16'hBEEF);
    do_write(30, 16'h5A5A);
    do_read(30);
    do_read(0);

    // R8: command while busy
    issue(0, 10, 16'h0);
    exp_q.push_back(exp_mem[5]);
    @(negedge clk); cmd_word = mk(1, 12, 16'hCAFE); cmd_we = 1;
    @(negedge clk); cmd_we = 0;
    chk("R8 payload unchanged", link_haddr, 5);
    chk("R8 overrun set", status[22], 1);
    for (int k = 0; k < 40 && st_f() != 3; k++) @(negedge clk);
    vldclr_we = 1; @(negedge clk); vldclr_we = 0;
    chk("R8 overrun sticky", status[22], 1);
    do_read(12);                // must not hold CAFE

    // R10
    chk("R10 init clear", status[21], 0);
    init_set = 1; @(negedge clk); init_set = 0;
    chk("R10 init set", status[21], 1);
    repeat (4) @(negedge clk);
    chk("R10 init sticky", status, 32'h0070_0000);

    repeat (4) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule